// File: doc/BRIEF.md
# Suspend modulation throttle generator

This block slows a processor core by driving its active-low suspend input in a repeating pattern. A running phase, with the output released, alternates with a suspended phase, with the output asserted. Each phase length is a byte count of 32 µs units. The core therefore delivers full speed × RUN / (RUN + SUSP) of its throughput. A 1 µs tick input sets the time base, and a prescaler inside the block turns it into the 32 µs unit.

Software programs the block through a byte-wide register port. The registers hold the two phase counts, a modulation enable bit, a power-management enable byte and two hold lengths in milliseconds. An interrupt event or a video event can pause throttling when its speedup is enabled. The pause holds the output released for that source's hold length. When the hold ends, modulation restarts by itself with a running phase.

Top module: `susp_throttle`

## Requirements
- R1: After a synchronous reset, `susp_n` is 1 and every register reads 0.
- R2: The registers are: power-management enable at 0x80, interrupt hold (ms) at 0x8C, video hold (ms) at 0x8D, running count at 0x94, suspended count at 0x95 and modulation config at 0x96. Each reads back what was last written to it. Reads of other addresses return 0, and writes to other addresses change no register.
- R3: While config bit 0 is 0, `susp_n` is 1. Clearing the bit during a suspended phase releases `susp_n` right after the write edge.
- R4: Setting config bit 0 starts a running phase (`susp_n`=1) lasting RUN×32 ticks. A suspended phase (`susp_n`=0) lasting SUSP×32 ticks follows, and the pair repeats.
- R5: With SUSP=0, `susp_n` stays 1. With RUN=0 and SUSP≠0, `susp_n` stays 0. With both counts 0, `susp_n` stays 1.
- R6: A write to either count never shortens or stretches the phase in progress. The new value is used from the next phase boundary on.
- R7: When enable bits 0 and 3 are both set and the interrupt hold is nonzero, a cycle with `irq_evt` high holds `susp_n` at 1 for hold×1000 ticks. Modulation then restarts with a full running phase.
- R8: When enable bits 0 and 4 are both set, `vid_evt` works the same way using the video hold length.
- R9: An event whose speedup bit or global bit 0 is clear has no effect on `susp_n`.
- R10: An event that arrives while its hold is running reloads the full hold length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity event |
| vid_evt | input | 1 | Video access event |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The phase engine is swept over every pairing of counts from {0, 1, 2, 5}, and each sample is compared with an arithmetic model over two full periods. This separates the ordinary duty cycles from the three zero-count cases. An extreme 255/1 pattern exercises full-width counts. A count written mid-phase shows whether the running phase is cut short or extended. Speedup is driven in several ways: a single event, a retriggered event, and events whose enable bits are missing. Together these distinguish a hold that starts at all, one that ends on time, one that reloads, and a restart that begins with the running phase.

// File: rtl/sm_pkg.sv
// Shared constants and types for the suspend modulation throttle.
// Assumes byte-wide register addresses.
package sm_pkg;
    localparam logic [7:0] A_PM_EN  = 8'h80;
    localparam logic [7:0] A_IRQ_MS = 8'h8C;
    localparam logic [7:0] A_VID_MS = 8'h8D;
    localparam logic [7:0] A_RUN    = 8'h94;
    localparam logic [7:0] A_SUSP   = 8'h95;
    localparam logic [7:0] A_CFG    = 8'h96;

    localparam int PM_GLOBAL_BIT = 0;
    localparam int PM_IRQ_BIT    = 3;
    localparam int PM_VID_BIT    = 4;
    localparam int CFG_MOD_BIT   = 0;

    typedef enum logic {PH_RUN = 1'b0, PH_SUSP = 1'b1} phase_t;

    typedef struct packed {
        phase_t     ph;
        logic [7:0] cnt;
    } phase_sel_t;
endpackage

// File: rtl/sm_regfile.sv
// Byte register file for the throttle. Writes land on the clock edge; reads
// are a combinational mux. Assumes one access per cycle; unmapped addresses
// read 0 and ignore writes.
module sm_regfile
    import sm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       mod_on,
    output logic       irq_gate,
    output logic       vid_gate,
    output logic [7:0] run_cnt,
    output logic [7:0] susp_cnt,
    output logic [7:0] irq_ms,
    output logic [7:0] vid_ms
);
    logic [7:0] pm_en, cfg;

    // Capture register writes; synchronous reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_en <= '0; cfg <= '0; run_cnt <= '0;
            susp_cnt <= '0; irq_ms <= '0; vid_ms <= '0;
        end else if (we) begin
            case (addr)
                A_PM_EN:  pm_en    <= wdata;
                A_IRQ_MS: irq_ms   <= wdata;
                A_VID_MS: vid_ms   <= wdata;
                A_RUN:    run_cnt  <= wdata;
                A_SUSP:   susp_cnt <= wdata;
                A_CFG:    cfg      <= wdata;
                default:  ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        case (addr)
            A_PM_EN:  rdata = pm_en;
            A_IRQ_MS: rdata = irq_ms;
            A_VID_MS: rdata = vid_ms;
            A_RUN:    rdata = run_cnt;
            A_SUSP:   rdata = susp_cnt;
            A_CFG:    rdata = cfg;
            default:  rdata = '0;
        endcase
    end

    // Decoded control bits.
    always_comb begin
        mod_on   = cfg[CFG_MOD_BIT];
        irq_gate = pm_en[PM_GLOBAL_BIT] & pm_en[PM_IRQ_BIT];
        vid_gate = pm_en[PM_GLOBAL_BIT] & pm_en[PM_VID_BIT];
    end
endmodule

// File: rtl/sm_phase.sv
// Phase engine: a prescaler divides us_tick into UNIT_US-tick units, and an
// 8-bit down counter alternates running and suspended phases. When run is low,
// everything returns to idle; on the first run cycle it starts fresh with the
// running phase. Counts are sampled only when a phase is loaded.
module sm_phase
    import sm_pkg::*;
#(
    parameter int UNIT_US = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       us_tick,
    input  logic [7:0] run_cnt,
    input  logic [7:0] susp_cnt,
    output logic       active,
    output logic       unit_end,
    output logic       in_susp
);
    localparam int PW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(UNIT_US - 1);

    logic [PW-1:0] pre;
    logic [7:0]    rem;
    phase_t        ph;
    phase_sel_t    nx_after_run, nx_fresh;

    // Candidate next phases: after a running phase, and a fresh start.
    always_comb begin
        nx_after_run = (susp_cnt != 8'd0) ? phase_sel_t'{PH_SUSP, susp_cnt}
                                          : phase_sel_t'{PH_RUN, run_cnt};
        if (run_cnt != 8'd0)       nx_fresh = phase_sel_t'{PH_RUN, run_cnt};
        else if (susp_cnt != 8'd0) nx_fresh = phase_sel_t'{PH_SUSP, susp_cnt};
        else                       nx_fresh = phase_sel_t'{PH_RUN, 8'd0};
    end

    // Unit boundary strobe from the prescaler.
    assign unit_end = active && us_tick && (pre == LAST);
    assign in_susp  = active && (ph == PH_SUSP);

    // Prescaler and phase counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active <= 1'b0; pre <= '0; ph <= PH_RUN; rem <= '0;
        end else if (!active) begin
            active <= 1'b1; pre <= '0;
            ph <= nx_fresh.ph; rem <= nx_fresh.cnt;
        end else begin
            if (us_tick) pre <= (pre == LAST) ? '0 : pre + 1'b1;
            if (unit_end) begin
                if (rem <= 8'd1) begin
                    if (ph == PH_RUN && rem != 8'd0) begin
                        ph <= nx_after_run.ph; rem <= nx_after_run.cnt;
                    end else begin
                        ph <= nx_fresh.ph; rem <= nx_fresh.cnt;
                    end
                end else begin
                    rem <= rem - 8'd1;
                end
            end
        end
    end
endmodule

// File: rtl/sm_hold.sv
// Speedup hold timer: a qualified trigger loads LEN milliseconds, and busy
// stays high until that many ms of us_tick have elapsed. A trigger while busy
// reloads. A zero length ignores the trigger.
module sm_hold #(
    parameter int MS_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       trig,
    input  logic [7:0] len,
    output logic       busy
);
    localparam int SW = (MS_US > 1) ? $clog2(MS_US) : 1;
    localparam logic [SW-1:0] LAST = SW'(MS_US - 1);

    logic [SW-1:0] sub;
    logic [7:0]    left;

    // Load on trigger, otherwise count down one ms per MS_US ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub <= '0; left <= '0;
        end else if (trig && len != 8'd0) begin
            sub <= '0; left <= len;
        end else if (left != 8'd0 && us_tick) begin
            if (sub == LAST) begin
                sub <= '0; left <= left - 8'd1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign busy = (left != 8'd0);
endmodule

// File: rtl/susp_throttle.sv
// Top level of the suspend modulation throttle. It ties together the register
// file, the phase engine and one hold timer per speedup source (interrupt =
// index 0, video = index 1). Assumes us_tick is synchronous to clk.
module susp_throttle #(
    parameter int UNIT_US = 32,
    parameter int MS_US   = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    localparam int NSRC = 2;

    logic            mod_on, irq_gate, vid_gate;
    logic [7:0]      off_cnt, on_cnt, irq_ms, vid_ms;
    logic [NSRC-1:0] hold_trig, hold_busy;
    logic [NSRC-1:0][7:0] hold_len;
    logic            run, ph_act, ph_unit, ph_susp;

    sm_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .mod_on(mod_on),
        .irq_gate(irq_gate), .vid_gate(vid_gate), .run_cnt(off_cnt),
        .susp_cnt(on_cnt), .irq_ms(irq_ms), .vid_ms(vid_ms)
    );

    // Qualified triggers and hold lengths per source.
    assign hold_trig = {vid_evt & vid_gate, irq_evt & irq_gate};
    assign hold_len  = {vid_ms, irq_ms};

    for (genvar i = 0; i < NSRC; i++) begin : g_hold
        sm_hold #(.MS_US(MS_US)) u_hold (
            .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
            .trig(hold_trig[i]), .len(hold_len[i]), .busy(hold_busy[i])
        );
    end

    // Modulation runs only when enabled and no hold is pending.
    assign run = mod_on & ~(|hold_busy);

    sm_phase #(.UNIT_US(UNIT_US)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .us_tick(us_tick),
        .run_cnt(off_cnt), .susp_cnt(on_cnt), .active(ph_act),
        .unit_end(ph_unit), .in_susp(ph_susp)
    );

    assign susp_n = ~(run & ph_susp);
endmodule

// File: rtl/susp_throttle_chk.sv
// Temporal checks for susp_throttle, attached through bind.
module susp_throttle_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       susp_n,
    input logic       mod_on,
    input logic [7:0] off_cnt,
    input logic [1:0] hold_trig,
    input logic [1:0][7:0] hold_len,
    input logic [1:0] hold_busy,
    input logic       ph_act,
    input logic       ph_unit,
    input logic       ph_susp
);
    // R1
    reset_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> susp_n);
    // R3
    mod_off_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_on |-> susp_n);
    // R7
    hold_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_busy) |-> susp_n);
    // R7
    irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_trig[0] && hold_len[0] != 8'd0) |=> hold_busy[0]);
    // R8
    vid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_trig[1] && hold_len[1] != 8'd0) |=> hold_busy[1]);
    // R4
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ph_act) && $past(off_cnt) != 8'd0) |-> susp_n);
    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_act && $past(ph_act) && !$past(ph_unit)) |-> $stable(ph_susp));
endmodule

bind susp_throttle susp_throttle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .susp_n(susp_n), .mod_on(mod_on),
    .off_cnt(off_cnt), .hold_trig(hold_trig), .hold_len(hold_len),
    .hold_busy(hold_busy), .ph_act(ph_act), .ph_unit(ph_unit),
    .ph_susp(ph_susp)
);

// File: tb/susp_throttle_tb.sv
module susp_throttle_tb;
    localparam int UNIT = 32;
    localparam int MSU  = 50;

    logic clk = 0, rst_n = 0, us_tick = 1, cfg_we = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
    logic irq_evt = 0, vid_evt = 0, susp_n;
    int n_run = 0, n_fail = 0, cyc = 0, t0 = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    susp_throttle #(.UNIT_US(UNIT), .MS_US(MSU)) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1 cfg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    // Enable modulation; t0 marks the edge at which the engine starts.
    task automatic start_mod();
        wr(8'h96, 8'h01);
        @(posedge clk); #1 t0 = cyc;
    endtask

    // Move to the negedge at time t (t >= current+1) after start.
    task automatic wait_t(input int t);
        do @(negedge clk); while (cyc - t0 < t);
    endtask

    function automatic bit exp_low(input int t, input int off, input int on);
        if (on == 0) return 0;
        if (off == 0) return 1;
        return (t % ((off + on) * UNIT)) >= off * UNIT;
    endfunction

    task automatic sweep(input int off, input int on, input int len, input string req);
        int bad_t = -1, bad_v = 0;
        wr(8'h94, 8'(off)); wr(8'h95, 8'(on));
        start_mod();
        for (int t = 0; t < len; t++) begin
            wait_t(t);
            if (bad_t < 0 && (susp_n == exp_low(t, off, on))) begin
                bad_t = t; bad_v = susp_n;
            end
        end
        chk(bad_t < 0, req, bad_v, bad_t < 0 ? bad_v : int'(!exp_low(bad_t, off, on)));
        wr(8'h96, 8'h00);
        @(negedge clk);
        chk(susp_n == 1, "R3", susp_n, 1);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] addrs [6] = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96};
        int vals [5] = '{0, 1, 2, 5, 3};
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        chk(susp_n == 1, "R1", susp_n, 1);
        for (int i = 0; i < 6; i++) begin
            rd(addrs[i], d); chk(d == 0, "R1", d, 0);
        end
        // R2 readback, unmapped access
        for (int i = 0; i < 6; i++) wr(addrs[i], 8'(8'h20 + 2 * i));
        wr(8'h90, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            rd(addrs[i], d); chk(d == 8'(8'h20 + 2 * i), "R2", d, 8'h20 + 2 * i);
        end
        rd(8'h90, d); chk(d == 0, "R2", d, 0);
        rd(8'h97, d); chk(d == 0, "R2", d, 0);
        chk(susp_n == 1, "R3", susp_n, 1);   // config bit 0 clear (0x2A)
        for (int i = 0; i < 6; i++) wr(addrs[i], 8'h00);

        // R4 / R5 sweep of count pairs
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                int p = (vals[a] + vals[b]) * UNIT;
                sweep(vals[a], vals[b], (p == 0) ? 4 * UNIT : 2 * p,
                      (vals[a] == 0 || vals[b] == 0) ? "R5" : "R4");
            end
        sweep(255, 1, 256 * UNIT + 64, "R4");

        // R3 disable in the middle of a suspended phase
        wr(8'h94, 8'd1); wr(8'h95, 8'd3);
        start_mod();
        wait_t(50); chk(susp_n == 0, "R3", susp_n, 0);
        wr(8'h96, 8'h00); #1 chk(susp_n == 1, "R3", susp_n, 1);
        @(negedge clk); chk(susp_n == 1, "R3", susp_n, 1);

        // R6 count change mid phase
        wr(8'h94, 8'd3); wr(8'h95, 8'd2);
        start_mod();
        wait_t(40); wr(8'h94, 8'd1);
        wait_t(95);  chk(susp_n == 1, "R6", susp_n, 1);
        wait_t(96);  chk(susp_n == 0, "R6", susp_n, 0);
        wait_t(159); chk(susp_n == 0, "R6", susp_n, 0);
        wait_t(160); chk(susp_n == 1, "R6", susp_n, 1);
        wait_t(191); chk(susp_n == 1, "R6", susp_n, 1);
        wait_t(192); chk(susp_n == 0, "R6", susp_n, 0);
        wr(8'h96, 8'h00);

        // R7 interrupt hold, 2 ms = 100 ticks
        wr(8'h94, 8'd2); wr(8'h95, 8'd2);
        wr(8'h80, 8'h09); wr(8'h8C, 8'd2); wr(8'h8D, 8'd3);
        start_mod();
        wait_t(70); chk(susp_n == 0, "R7", susp_n, 0);
        irq_evt = 1;
        wait_t(71); irq_evt = 0; chk(susp_n == 1, "R7", susp_n, 1);
        wait_t(170); chk(susp_n == 1, "R7", susp_n, 1);
        wait_t(235); chk(susp_n == 1, "R7", susp_n, 1);
        wait_t(236); chk(susp_n == 0, "R7", susp_n, 0);
        wr(8'h96, 8'h00);

        // R9 events without their enables
        wr(8'h80, 8'h10);
        start_mod();
        wait_t(70); irq_evt = 1; vid_evt = 1;
        wait_t(71); irq_evt = 0; vid_evt = 0;
        chk(susp_n == 0, "R9", susp_n, 0);
        wait_t(72); chk(susp_n == 0, "R9", susp_n, 0);
        wr(8'h96, 8'h00);

        // R8 / R10 video hold, 3 ms = 150 ticks, retriggered
        wr(8'h80, 8'h11);
        start_mod();
        wait_t(80); vid_evt = 1;
        wait_t(81); vid_evt = 0; chk(susp_n == 1, "R8", susp_n, 1);
        wait_t(150); vid_evt = 1;
        wait_t(151); vid_evt = 0;
        wait_t(300); chk(susp_n == 1, "R10", susp_n, 1);
        wait_t(365); chk(susp_n == 1, "R10", susp_n, 1);
        wait_t(366); chk(susp_n == 0, "R8", susp_n, 0);
        wr(8'h96, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule